// File: doc/BRIEF.md
# Interprocessor Mailbox with Queue Interrupts

This block is a register-mapped mailbox that lets several processors pass 32-bit words to each other. It holds a number of shared message queues. Writing a queue's message register pushes a word into it, and reading the same register pops the oldest word. Each queue also shows a full flag and an occupancy count.

Every processor, called a user here, has its own interrupt state. It has a status register and an enable mask. The status register carries two event bits per queue: one for a pushed message and one for a queue that has just left the full state. A user's interrupt line is raised whenever an enabled status bit is set. Software acknowledges an event by writing a one to its status bit. The enable mask is changed through separate set and clear registers.

Access is through a plain register bus with one address, a write strobe, a read strobe, and write and read data. Read data is registered and is valid in the cycle after the read strobe. When the read and write strobes are raised together on a message register, the pop is applied before the push.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, every queue is empty and every status bit, enable bit, interrupt line and read-data bit is 0.
- R2: A write to the message register of queue m (offset 0x040 + 4·m) appends the word. Reads of that register return the words in the order they were written, one per read, in the cycle after the read strobe.
- R3: A queue holds 4 words. Its full register (offset 0x080 + 4·m) reads 1 when it holds 4 words and 0 otherwise. A write to a full queue is dropped and leaves the stored words intact.
- R4: A read of an empty queue's message register returns 0 and leaves its count at 0.
- R5: The count register of queue m (offset 0x0C0 + 4·m) reads the number of words held.
- R6: An accepted push into queue m sets status bit 2·m of every user in the next cycle.
- R7: A pop that takes queue m from 4 words to 3 sets status bit 2·m+1 of every user.
- R8: Writing the status register of user u (offset 0x104 + 0x10·u) clears exactly the bits written as 1. The bits written as 0 are unchanged, and other users are unaffected.
- R9: Writing the enable-set register (offset 0x108 + 0x10·u) ORs the written ones into the mask of user u. Writing the enable-clear register (offset 0x10C + 0x10·u) removes them. Both registers read back the current mask.
- R10: Interrupt line u is 1 exactly when the status of user u ANDed with its mask is nonzero.
- R11: The revision register (offset 0x000) reads the major number 2 in bits [7:4] and the minor number 1 in bits [3:0].
- R12: Writes to the revision, full and count registers have no effect.
- R13: A combined read and write on the message register of a full queue returns the oldest word and accepts the new word. The count stays at 4, status bit 2·m is set, and status bit 2·m+1 is not set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 12 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after rd_en |
| irq | output | NU | One interrupt line per user |

## Verification
A pop and a push can land on the same queue in the same cycle when the read and write strobes are raised together on its message register. The bench provokes this on a full queue. The read data must be the oldest word. The count must stay at 4. Only the new-message event may appear in the status, with no not-full event. Draining the queue afterwards must yield the three older words followed by the word that was written.

// File: rtl/ipc_mbx_pkg.sv
package ipc_mbx_pkg;

    localparam int BUS_AW       = 12;
    localparam int BUS_DW       = 32;

    localparam int REV_OFS      = 'h000;
    localparam int MSG_OFS      = 'h040;
    localparam int FULL_OFS     = 'h080;
    localparam int CNT_OFS      = 'h0C0;
    localparam int USER_OFS     = 'h100;
    localparam int USER_STRIDE  = 'h10;
    localparam int SUB_STATUS   = 'h4;
    localparam int SUB_EN_SET   = 'h8;
    localparam int SUB_EN_CLR   = 'hC;

    typedef enum logic [2:0] {
        RG_NONE,
        RG_REV,
        RG_MSG,
        RG_FULL,
        RG_CNT,
        RG_STAT,
        RG_ESET,
        RG_ECLR
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e  kind;
        logic [7:0] idx;
    } reg_sel_t;

    // bit position of the new-message event of queue q
    function automatic int newmsg_bit(input int q);
        return 2 * q;
    endfunction

    // bit position of the not-full event of queue q
    function automatic int notfull_bit(input int q);
        return 2 * q + 1;
    endfunction

    function automatic reg_sel_t decode_addr(input logic [BUS_AW-1:0] a,
                                             input int nq, input int nu);
        reg_sel_t s;
        int       ai;
        int       off;
        s.kind = RG_NONE;
        s.idx  = '0;
        ai     = int'(a);
        if (a[1:0] == 2'b00) begin
            if (ai == REV_OFS) begin
                s.kind = RG_REV;
            end else if (ai >= MSG_OFS && ai < MSG_OFS + 4 * nq) begin
                s.kind = RG_MSG;
                s.idx  = 8'((ai - MSG_OFS) / 4);
            end else if (ai >= FULL_OFS && ai < FULL_OFS + 4 * nq) begin
                s.kind = RG_FULL;
                s.idx  = 8'((ai - FULL_OFS) / 4);
            end else if (ai >= CNT_OFS && ai < CNT_OFS + 4 * nq) begin
                s.kind = RG_CNT;
                s.idx  = 8'((ai - CNT_OFS) / 4);
            end else if (ai >= USER_OFS && ai < USER_OFS + USER_STRIDE * nu) begin
                off   = ai - USER_OFS;
                s.idx = 8'(off / USER_STRIDE);
                case (off % USER_STRIDE)
                    SUB_STATUS: s.kind = RG_STAT;
                    SUB_EN_SET: s.kind = RG_ESET;
                    SUB_EN_CLR: s.kind = RG_ECLR;
                    default:    s.kind = RG_NONE;
                endcase
            end
        end
        return s;
    endfunction

endpackage

// File: rtl/ipc_mbx_queue.sv
module ipc_mbx_queue #(
    parameter  int DEPTH = 4,
    parameter  int DW    = 32,
    localparam int CW    = $clog2(DEPTH + 1),
    localparam int PW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic          pop,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] head,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          evt_new,
    output logic          evt_notfull
);

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          pop_ok, push_ok;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CW'(DEPTH));
    assign pop_ok  = pop && (count != '0);
    // a pop in the same cycle frees the slot the push needs
    assign push_ok = push && (!full || pop_ok);
    assign head    = mem[rd_ptr];

    assign evt_new     = push_ok;
    assign evt_notfull = pop_ok && !push_ok && full;

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= ptr_next(wr_ptr);
            if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CW'(DEPTH));

    assert_drop_when_full_R3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> (count == CW'(DEPTH)) && $stable(rd_ptr));

    assert_empty_pop_R4: assert property (@(posedge clk) disable iff (rst)
        ((count == '0) && pop && !push) |=> (count == '0));

endmodule

// File: rtl/ipc_mbx_user_irq.sv
module ipc_mbx_user_irq #(
    parameter int NEV = 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NEV-1:0] evt,
    input  logic           w1c_we,
    input  logic           eset_we,
    input  logic           eclr_we,
    input  logic [NEV-1:0] wbits,
    output logic [NEV-1:0] status,
    output logic [NEV-1:0] enable,
    output logic           irq
);

    logic [NEV-1:0] clr_mask;

    assign clr_mask = w1c_we ? wbits : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
            enable <= '0;
        end else begin
            // a new event wins over an acknowledge in the same cycle
            status <= (status & ~clr_mask) | evt;
            if (eset_we) begin
                enable <= enable | wbits;
            end else if (eclr_we) begin
                enable <= enable & ~wbits;
            end
        end
    end

    assign irq = |(status & enable);

    assert_event_sets_R6: assert property (@(posedge clk) disable iff (rst)
        (|evt) |=> ((status & $past(evt)) == $past(evt)));

    assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (rst)
        (w1c_we && (|(wbits & ~evt))) |=> ((status & $past(wbits & ~evt)) == '0));

    assert_w1c_keeps_R8: assert property (@(posedge clk) disable iff (rst)
        w1c_we |=> ((status & ~$past(wbits)) == ($past(status) & ~$past(wbits)) | ($past(evt) & ~$past(wbits))));

    assert_enable_set_R9: assert property (@(posedge clk) disable iff (rst)
        eset_we |=> ((enable & $past(wbits)) == $past(wbits)));

    assert_enable_clr_R9: assert property (@(posedge clk) disable iff (rst)
        eclr_we |=> ((enable & $past(wbits)) == '0));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import ipc_mbx_pkg::*;
#(
    parameter  int NQ        = 4,
    parameter  int NU        = 4,
    parameter  int DEPTH     = 4,
    parameter  int REV_MAJOR = 2,
    parameter  int REV_MINOR = 1,
    localparam int NEV       = 2 * NQ,
    localparam int CW        = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BUS_AW-1:0] addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [BUS_DW-1:0] wdata,
    output logic [BUS_DW-1:0] rdata,
    output logic [NU-1:0]     irq
);

    reg_sel_t          sel;
    logic [BUS_DW-1:0] q_head [NQ];
    logic [CW-1:0]     q_cnt  [NQ];
    logic [NQ-1:0]     q_full;
    logic [NEV-1:0]    evt;
    logic [NEV-1:0]    u_status [NU];
    logic [NEV-1:0]    u_enable [NU];
    logic [BUS_DW-1:0] rd_mux;
    logic              sel_empty;

    assign sel = decode_addr(addr, NQ, NU);

    for (genvar q = 0; q < NQ; q++) begin : g_queue
        logic hit;
        assign hit = (sel.kind == RG_MSG) && (sel.idx == 8'(q));

        ipc_mbx_queue #(.DEPTH(DEPTH), .DW(BUS_DW)) u_queue (
            .clk         (clk),
            .rst         (rst),
            .push        (wr_en && hit),
            .pop         (rd_en && hit),
            .din         (wdata),
            .head        (q_head[q]),
            .count       (q_cnt[q]),
            .full        (q_full[q]),
            .evt_new     (evt[newmsg_bit(q)]),
            .evt_notfull (evt[notfull_bit(q)])
        );
    end

    for (genvar u = 0; u < NU; u++) begin : g_user
        logic mine;
        assign mine = (sel.idx == 8'(u));

        ipc_mbx_user_irq #(.NEV(NEV)) u_irq (
            .clk     (clk),
            .rst     (rst),
            .evt     (evt),
            .w1c_we  (wr_en && mine && (sel.kind == RG_STAT)),
            .eset_we (wr_en && mine && (sel.kind == RG_ESET)),
            .eclr_we (wr_en && mine && (sel.kind == RG_ECLR)),
            .wbits   (wdata[NEV-1:0]),
            .status  (u_status[u]),
            .enable  (u_enable[u]),
            .irq     (irq[u])
        );
    end

    always_comb begin
        rd_mux    = '0;
        sel_empty = 1'b0;
        case (sel.kind)
            RG_REV: rd_mux[7:0] = {4'(REV_MAJOR), 4'(REV_MINOR)};
            RG_MSG, RG_FULL, RG_CNT: begin
                for (int q = 0; q < NQ; q++) begin
                    if (sel.idx == 8'(q)) begin
                        sel_empty = (q_cnt[q] == '0);
                        if (sel.kind == RG_MSG) begin
                            rd_mux = sel_empty ? '0 : q_head[q];
                        end else if (sel.kind == RG_FULL) begin
                            rd_mux[0] = q_full[q];
                        end else begin
                            rd_mux[CW-1:0] = q_cnt[q];
                        end
                    end
                end
            end
            RG_STAT, RG_ESET, RG_ECLR: begin
                for (int u = 0; u < NU; u++) begin
                    if (sel.idx == 8'(u)) begin
                        rd_mux[NEV-1:0] = (sel.kind == RG_STAT) ? u_status[u] : u_enable[u];
                    end
                end
            end
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            rdata <= rd_mux;
        end
    end

    assert_empty_read_zero_R4: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (sel.kind == RG_MSG) && sel_empty) |=> (rdata == '0));

    assert_revision_R11: assert property (@(posedge clk) disable iff (rst)
        (rd_en && (sel.kind == RG_REV)) |=> (rdata[7:4] == 4'(REV_MAJOR) && rdata[3:0] == 4'(REV_MINOR)));

endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    localparam int NQ = 4;
    localparam int NU = 4;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [11:0]   addr = '0;
    logic          wr_en = 1'b0;
    logic          rd_en = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NU-1:0] irq;

    int  n_chk = 0;
    int  n_err = 0;
    bit  done  = 1'b0;

    always #2 clk = ~clk;

    ipc_mailbox #(.NQ(NQ), .NU(NU), .DEPTH(4)) u_dut (
        .clk   (clk),
        .rst   (rst),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata),
        .irq   (irq)
    );

    // {req, pad, rd, addr, data}
    localparam int NV = 39;
    localparam logic [51:0] VEC [NV] = '{
        {4'd11, 3'b0, 1'b1, 12'h000, 32'h0000_0021},  // R11 revision
        {4'd1,  3'b0, 1'b1, 12'h0C0, 32'h0},          // R1 empty after reset
        {4'd1,  3'b0, 1'b1, 12'h104, 32'h0},          // R1 status clear
        {4'd2,  3'b0, 1'b0, 12'h040, 32'h1111_1111},  // R2 push
        {4'd2,  3'b0, 1'b0, 12'h040, 32'h2222_2222},
        {4'd5,  3'b0, 1'b1, 12'h0C0, 32'h2},          // R5 count
        {4'd6,  3'b0, 1'b1, 12'h104, 32'h1},          // R6 user 0
        {4'd6,  3'b0, 1'b1, 12'h134, 32'h1},          // R6 user 3
        {4'd2,  3'b0, 1'b1, 12'h040, 32'h1111_1111},  // R2 order
        {4'd2,  3'b0, 1'b1, 12'h040, 32'h2222_2222},
        {4'd4,  3'b0, 1'b1, 12'h040, 32'h0},          // R4 empty read
        {4'd4,  3'b0, 1'b1, 12'h0C0, 32'h0},
        {4'd12, 3'b0, 1'b0, 12'h0C0, 32'h5},          // R12 write to count
        {4'd12, 3'b0, 1'b1, 12'h0C0, 32'h0},
        {4'd12, 3'b0, 1'b0, 12'h000, 32'hFF},         // R12 write to revision
        {4'd12, 3'b0, 1'b1, 12'h000, 32'h0000_0021},
        {4'd8,  3'b0, 1'b0, 12'h104, 32'h1},          // R8 acknowledge
        {4'd8,  3'b0, 1'b1, 12'h104, 32'h0},
        {4'd8,  3'b0, 1'b1, 12'h114, 32'h1},          // R8 other user kept
        {4'd2,  3'b0, 1'b0, 12'h048, 32'hA0},
        {4'd2,  3'b0, 1'b0, 12'h048, 32'hA1},
        {4'd2,  3'b0, 1'b0, 12'h048, 32'hA2},
        {4'd2,  3'b0, 1'b0, 12'h048, 32'hA3},
        {4'd3,  3'b0, 1'b1, 12'h088, 32'h1},          // R3 full
        {4'd3,  3'b0, 1'b0, 12'h048, 32'hDEAD_DEAD},  // R3 dropped write
        {4'd5,  3'b0, 1'b1, 12'h0C8, 32'h4},          // R5
        {4'd2,  3'b0, 1'b1, 12'h048, 32'hA0},
        {4'd7,  3'b0, 1'b1, 12'h114, 32'h31},         // R7 not-full event
        {4'd3,  3'b0, 1'b1, 12'h088, 32'h0},
        {4'd2,  3'b0, 1'b1, 12'h048, 32'hA1},
        {4'd2,  3'b0, 1'b1, 12'h048, 32'hA2},
        {4'd3,  3'b0, 1'b1, 12'h048, 32'hA3},
        {4'd4,  3'b0, 1'b1, 12'h048, 32'h0},          // R4 / R3 nothing extra
        {4'd9,  3'b0, 1'b0, 12'h108, 32'h30},         // R9 set
        {4'd9,  3'b0, 1'b1, 12'h108, 32'h30},
        {4'd9,  3'b0, 1'b0, 12'h10C, 32'h10},         // R9 clear
        {4'd9,  3'b0, 1'b1, 12'h108, 32'h20},
        {4'd9,  3'b0, 1'b1, 12'h10C, 32'h20},
        {4'd6,  3'b0, 1'b1, 12'h104, 32'h30}
    };

    task automatic check(input int req, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL R%0d: actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic bus_rw(input logic [11:0] a, input logic [31:0] wd, output logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = wd; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(1, {28'h0, irq}, 32'h0);       // R1 irq low
        check(1, rdata, 32'h0);              // R1 rdata low

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][44]) begin
                bus_rd(VEC[i][43:32], d);
                check(int'(VEC[i][51:48]), d, VEC[i][31:0]);
            end else begin
                bus_wr(VEC[i][43:32], VEC[i][31:0]);
            end
        end

        // R10: user0 status 0x30, mask 0x20
        @(negedge clk);
        check(10, {28'h0, irq}, 32'h1);
        bus_wr(12'h104, 32'h20);             // R8 acknowledge the enabled bit
        @(negedge clk);
        check(10, {28'h0, irq}, 32'h0);
        bus_wr(12'h128, 32'h1);              // R10 user2 status bit0 pending
        @(negedge clk);
        check(10, {28'h0, irq}, 32'h4);
        bus_wr(12'h12C, 32'h1);
        @(negedge clk);
        check(10, {28'h0, irq}, 32'h0);

        // R13: pop and push together on a full queue
        bus_wr(12'h104, 32'hFF);
        bus_wr(12'h044, 32'hB0);
        bus_wr(12'h044, 32'hB1);
        bus_wr(12'h044, 32'hB2);
        bus_wr(12'h044, 32'hB3);
        bus_wr(12'h104, 32'hFF);
        bus_rw(12'h044, 32'hBEEF, d);
        check(13, d, 32'hB0);
        bus_rd(12'h0C4, d);
        check(13, d, 32'h4);
        bus_rd(12'h104, d);
        check(13, d, 32'h4);
        bus_rd(12'h084, d);
        check(13, d, 32'h1);
        bus_rd(12'h044, d);
        check(13, d, 32'hB1);
        bus_rd(12'h044, d);
        check(13, d, 32'hB2);
        bus_rd(12'h044, d);
        check(13, d, 32'hB3);
        bus_rd(12'h044, d);
        check(13, d, 32'hBEEF);

        // R1: reset in the middle of a run
        bus_wr(12'h040, 32'h77);
        bus_wr(12'h108, 32'h1);
        @(negedge clk);
        check(10, {28'h0, irq}, 32'h1);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(1, {28'h0, irq}, 32'h0);
        check(1, rdata, 32'h0);
        bus_rd(12'h0C0, d);
        check(1, d, 32'h0);
        bus_rd(12'h108, d);
        check(1, d, 32'h0);
        bus_rd(12'h104, d);
        check(1, d, 32'h0);
        bus_rd(12'h040, d);
        check(1, d, 32'h0);

        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule